// File: doc/BRIEF.md
# Clear-then-Diagonal Pixel Sweeper

This block produces a stream of pixel writes for a raster store. One `start` pulse launches two phases, one after the other. The first phase wipes a square patch of the screen to color 0. It presents one coordinate per clock: the column runs fast and the row runs slow. The second phase draws a single 45-degree line that rises from left to right, in color 1. On that line the column climbs by one and the row falls by one on every cycle. The line begins at row 100 of column 0 and ends at column 100 of row 0.

A write takes place in every cycle in which `wr_en` is high. In that cycle `pix_x`, `pix_y` and `pix_color` describe the write. Between the two phases there is one idle cycle, which loads the line's start point into the coordinate counters. After the last line pixel the block raises `sweep_done`. It holds that flag until a new `start` arrives, and that new `start` runs the whole sequence again. The reset input acts at once when it is asserted. Its release is synchronised internally, and this takes two clocks.

Top module: `clear_diag_draw`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `wr_en`, `sweep_done`, `pix_x`, `pix_y` and `pix_color` are all 0. Asserting reset in the middle of a run forces them to 0 at once.
- R2: A start sampled in the idle state makes the cycle after that edge present pixel (0,0) with `wr_en` high and color 0.
- R3: The wipe phase presents 14,400 consecutive writes of color 0. Within a row, x steps from 0 to 119 and then wraps to 0 while y increments. y steps from 0 to 119, so the last wipe pixel is (119,119).
- R4: The cycle after pixel (119,119) has `wr_en` low and `sweep_done` low.
- R5: The line phase presents 101 consecutive writes of color 1. These start at (0,100), and on each cycle x increments and y decrements, so that x+y = 100 throughout. `pix_color` is 0 in every cycle that is not a line write.
- R6: The cycle after line pixel (100,0) has `sweep_done` high and `wr_en` low. Both stay that way until a start is sampled.
- R7: A start that is sampled during the wipe phase or the line phase has no effect on the pixel sequence.
- R8: A start sampled while `sweep_done` is high lowers `sweep_done`, and the next cycle presents (0,0) with `wr_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Assertion is asynchronous; release is synchronised |
| start | input | 1 | Launches a sweep when sampled in the idle or done state |
| pix_x | output | 7 | Column of the current write |
| pix_y | output | 7 | Row of the current write |
| pix_color | output | 3 | Color of the current write (0 = wipe, 1 = line) |
| wr_en | output | 1 | High in cycles that carry a valid pixel write |
| sweep_done | output | 1 | High once the line is finished, until the next start |

## Verification
Take N as the number of clock cycles after the edge that samples `start`. Wipe pixel k is due at N = k+1. The load gap falls at N = 14,401. Line pixel j is due at N = 14,402+j, and `sweep_done` rises at N = 14,503. The bench drives and samples one nanosecond after each rising edge and keeps a cycle index from the start edge. Each output is compared with the value computed for that index, in every cycle of the run, and a table of key indices gets individual checks. A reset asserted in the middle of a run is checked immediately, without waiting for an edge, because the reset acts asynchronously.

// File: rtl/cdd_pkg.sv
package cdd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WIPE  = 2'd1,
    ST_LINE  = 2'd2,
    ST_DONE  = 2'd3
  } sweep_state_e;
endpackage

// File: rtl/cdd_rst_sync.sv
module cdd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cdd_coord_dp.sv
module cdd_coord_dp #(
  parameter int CW       = 7,
  parameter int WIPE_MAX = 119,
  parameter int LINE_Y0  = 100,
  parameter int LINE_LEN = 101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe_load,
  input  logic          wipe_step,
  input  logic          line_load,
  input  logic          line_step,
  output logic [CW-1:0] cx,
  output logic [CW-1:0] cy,
  output logic          wipe_last,
  output logic          line_last
);
  localparam logic [CW-1:0] WMAX  = CW'(WIPE_MAX);
  localparam logic [CW-1:0] Y0    = CW'(LINE_Y0);
  localparam logic [CW:0]   XSTOP = (CW+1)'(LINE_LEN);

  logic [CW-1:0] cx_nxt, cy_nxt;
  logic          cnt_en;
  logic [CW:0]   cx_inc;

  assign cnt_en = wipe_load | wipe_step | line_load | line_step;
  assign cx_inc = {1'b0, cx} + (CW+1)'(1);

  // end-of-phase comparators
  assign wipe_last = (cx == WMAX) && (cy == WMAX);
  assign line_last = (cx_inc == XSTOP);

  always_comb begin
    cx_nxt = cx;
    cy_nxt = cy;
    if (wipe_load) begin
      cx_nxt = '0;
      cy_nxt = '0;
    end else if (line_load) begin
      cx_nxt = '0;
      cy_nxt = Y0;
    end else if (wipe_step) begin
      if (cx == WMAX) begin
        cx_nxt = '0;
        cy_nxt = cy + CW'(1);
      end else begin
        cx_nxt = cx_inc[CW-1:0];
      end
    end else if (line_step) begin
      cx_nxt = cx_inc[CW-1:0];
      cy_nxt = cy - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cx <= '0;
      cy <= '0;
    end else if (cnt_en) begin
      cx <= cx_nxt;
      cy <= cy_nxt;
    end
  end
endmodule

// File: rtl/cdd_seq_ctrl.sv
module cdd_seq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic wipe_last,
  input  logic line_last,
  output logic wipe_load,
  output logic wipe_step,
  output logic line_load,
  output logic line_step,
  output logic wipe_pix,
  output logic line_pix,
  output logic fin
);
  import cdd_pkg::*;

  sweep_state_e st_q, st_nxt;
  logic         live_q, live_nxt;

  always_comb begin
    st_nxt    = st_q;
    live_nxt  = live_q;
    wipe_load = 1'b0;
    wipe_step = 1'b0;
    line_load = 1'b0;
    line_step = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          st_nxt    = ST_WIPE;
          wipe_load = 1'b1;
          live_nxt  = 1'b0;
        end
      end
      ST_WIPE: begin
        if (wipe_last) begin
          st_nxt   = ST_LINE;
          live_nxt = 1'b0;
        end else begin
          wipe_step = 1'b1;
        end
      end
      ST_LINE: begin
        if (!live_q) begin
          line_load = 1'b1;
          live_nxt  = 1'b1;
        end else if (line_last) begin
          st_nxt   = ST_DONE;
          live_nxt = 1'b0;
        end else begin
          line_step = 1'b1;
        end
      end
      default: begin
        st_nxt   = ST_IDLE;
        live_nxt = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      live_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      live_q <= live_nxt;
    end
  end

  assign wipe_pix = (st_q == ST_WIPE);
  assign line_pix = (st_q == ST_LINE) && live_q;
  assign fin      = (st_q == ST_DONE);
endmodule

// File: rtl/clear_diag_draw.sv
module clear_diag_draw #(
  parameter int WIPE_MAX   = 119,
  parameter int LINE_Y0    = 100,
  parameter int LINE_LEN   = 101,
  parameter int COLOR_W    = 3,
  parameter int LINE_COLOR = 1,
  parameter int CW         = $clog2(((WIPE_MAX > LINE_LEN) ? WIPE_MAX : LINE_LEN) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic [CW-1:0]      pix_x,
  output logic [CW-1:0]      pix_y,
  output logic [COLOR_W-1:0] pix_color,
  output logic               wr_en,
  output logic               sweep_done
);
  localparam logic [COLOR_W-1:0] LCOL = COLOR_W'(LINE_COLOR);

  logic rst_n_i;
  logic wipe_load, wipe_step, line_load, line_step;
  logic wipe_last, line_last;
  logic wipe_pix, line_pix, fin;

  cdd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  cdd_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start     (start),
    .wipe_last (wipe_last),
    .line_last (line_last),
    .wipe_load (wipe_load),
    .wipe_step (wipe_step),
    .line_load (line_load),
    .line_step (line_step),
    .wipe_pix  (wipe_pix),
    .line_pix  (line_pix),
    .fin       (fin)
  );

  cdd_coord_dp #(
    .CW       (CW),
    .WIPE_MAX (WIPE_MAX),
    .LINE_Y0  (LINE_Y0),
    .LINE_LEN (LINE_LEN)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wipe_load (wipe_load),
    .wipe_step (wipe_step),
    .line_load (line_load),
    .line_step (line_step),
    .cx        (pix_x),
    .cy        (pix_y),
    .wipe_last (wipe_last),
    .line_last (line_last)
  );

  assign wr_en      = wipe_pix | line_pix;
  assign pix_color  = line_pix ? LCOL : '0;
  assign sweep_done = fin;
endmodule

// File: rtl/cdd_chk.sv
module cdd_chk #(
  parameter int WIPE_MAX = 119,
  parameter int LINE_Y0  = 100,
  parameter int LINE_LEN = 101,
  parameter int COLOR_W  = 3,
  parameter int CW       = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [CW-1:0]      pix_x,
  input logic [CW-1:0]      pix_y,
  input logic [COLOR_W-1:0] pix_color,
  input logic               wr_en,
  input logic               sweep_done
);
  logic is_wipe, is_line;
  assign is_wipe = wr_en && (pix_color == '0);
  assign is_line = wr_en && (pix_color != '0);

  AST_WIPE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wipe && int'(pix_x) != WIPE_MAX) |=> (is_wipe && pix_x == $past(pix_x) + CW'(1) && pix_y == $past(pix_y))); // R3
  AST_WIPE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wipe && int'(pix_x) == WIPE_MAX && int'(pix_y) != WIPE_MAX) |=> (is_wipe && pix_x == '0 && pix_y == $past(pix_y) + CW'(1))); // R3
  AST_LOAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wipe && int'(pix_x) == WIPE_MAX && int'(pix_y) == WIPE_MAX) |=> (!wr_en && !sweep_done)); // R4
  AST_LINE_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
    is_line |-> (int'(pix_x) + int'(pix_y) == LINE_Y0)); // R5
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_line && int'(pix_x) != LINE_LEN - 1) |=> (is_line && pix_x == $past(pix_x) + CW'(1))); // R5
  AST_LINE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (is_line && int'(pix_x) == LINE_LEN - 1) |=> (sweep_done && !wr_en)); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> (!wr_en && pix_color == '0)); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_done && !start) |=> sweep_done); // R6
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_done && start) |=> (!sweep_done && wr_en && pix_x == '0 && pix_y == '0)); // R8
endmodule

bind clear_diag_draw cdd_chk #(
  .WIPE_MAX (WIPE_MAX),
  .LINE_Y0  (LINE_Y0),
  .LINE_LEN (LINE_LEN),
  .COLOR_W  (COLOR_W),
  .CW       (CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .pix_x      (pix_x),
  .pix_y      (pix_y),
  .pix_color  (pix_color),
  .wr_en      (wr_en),
  .sweep_done (sweep_done)
);

// File: tb/sim_clear_diag_draw.sv
`timescale 1ns/1ps
module sim_clear_diag_draw;
  localparam int NWIPE = 14400;
  localparam int NGAP  = NWIPE;
  localparam int NL0   = NWIPE + 1;
  localparam int NDONE = NL0 + 101;
  localparam int NVEC  = 8;
  // columns: cycle index, requirement, x, y, color, wr_en, done  (-1 = ignore)
  localparam int VEC [NVEC][7] = '{
    '{0,     2, 0,   0,   0, 1, 0},
    '{119,   3, 119, 0,   0, 1, 0},
    '{120,   3, 0,   1,   0, 1, 0},
    '{14399, 3, 119, 119, 0, 1, 0},
    '{14400, 4, -1,  -1,  0, 0, 0},
    '{14401, 5, 0,   100, 1, 1, 0},
    '{14501, 5, 100, 0,   1, 1, 0},
    '{14502, 6, -1,  -1,  0, 0, 1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [6:0] pix_x, pix_y;
  logic [2:0] pix_color;
  logic       wr_en, sweep_done;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  clear_diag_draw u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pix_x(pix_x), .pix_y(pix_y), .pix_color(pix_color),
    .wr_en(wr_en), .sweep_done(sweep_done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic kick;
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic check_quiet(input string req);
    chk(wr_en == 1'b0, req, "wr_en", int'(wr_en), 0);
    chk(sweep_done == 1'b0, req, "sweep_done", int'(sweep_done), 0);
    chk(pix_x == 7'd0 && pix_y == 7'd0, req, "coords", int'(pix_x) * 1000 + int'(pix_y), 0);
    chk(pix_color == 3'd0, req, "color", int'(pix_color), 0);
  endtask

  // Walk one full sweep; index n = cycles after the start edge (minus one).
  task automatic run_seq(input int inj_a, input int inj_b, input string tag);
    int wipe_bad = 0, gap_bad = 0, line_bad = 0, done_bad = 0, ti = 0;
    for (int n = 0; n <= NDONE; n++) begin
      if (n < NGAP) begin
        if (!(wr_en && !sweep_done && pix_color == 0 && int'(pix_x) == n % 120 && int'(pix_y) == n / 120)) wipe_bad++;
      end else if (n == NGAP) begin
        if (wr_en || sweep_done || pix_color != 0) gap_bad++;
      end else if (n < NDONE) begin
        if (!(wr_en && !sweep_done && pix_color == 1 && int'(pix_x) == n - NL0 && int'(pix_y) == 100 - (n - NL0))) line_bad++;
      end else begin
        if (wr_en || !sweep_done || pix_color != 0) done_bad++;
      end
      if (ti < NVEC && VEC[ti][0] == n) begin
        string rq;
        rq = $sformatf("R%0d", VEC[ti][1]);
        if (VEC[ti][2] >= 0) chk(int'(pix_x) == VEC[ti][2], rq, $sformatf("%s x@%0d", tag, n), int'(pix_x), VEC[ti][2]);
        if (VEC[ti][3] >= 0) chk(int'(pix_y) == VEC[ti][3], rq, $sformatf("%s y@%0d", tag, n), int'(pix_y), VEC[ti][3]);
        chk(int'(pix_color) == VEC[ti][4], rq, $sformatf("%s color@%0d", tag, n), int'(pix_color), VEC[ti][4]);
        chk(int'(wr_en) == VEC[ti][5], rq, $sformatf("%s wr_en@%0d", tag, n), int'(wr_en), VEC[ti][5]);
        chk(int'(sweep_done) == VEC[ti][6], rq, $sformatf("%s done@%0d", tag, n), int'(sweep_done), VEC[ti][6]);
        ti++;
      end
      if (n == inj_a || n == inj_b) start = 1'b1;
      if (n < NDONE) begin
        tick();
        start = 1'b0;
      end
    end
    chk(wipe_bad == 0, "R3", {tag, " wipe mismatches"}, wipe_bad, 0);
    chk(gap_bad == 0, "R4", {tag, " gap mismatches"}, gap_bad, 0);
    chk(line_bad == 0, "R5", {tag, " line mismatches"}, line_bad, 0);
    chk(done_bad == 0, "R6", {tag, " done mismatches"}, done_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) tick();
    check_quiet("R1");
    rst_n = 1'b1;
    repeat (4) tick();
    check_quiet("R1");

    // R2..R6 with start pulses injected mid-wipe and mid-line (R7)
    kick();
    run_seq(500, 14450, "R7_inject");
    tick();
    start = 1'b0;
    repeat (20) tick();
    chk(sweep_done == 1'b1, "R6", "done held", int'(sweep_done), 1);
    chk(wr_en == 1'b0, "R6", "no write held", int'(wr_en), 0);

    // R8: restart from the done state
    kick();
    chk(sweep_done == 1'b0, "R8", "done dropped", int'(sweep_done), 1'b0);
    run_seq(-1, -1, "R8_restart");

    // R1: reset asserted in the middle of the line phase
    tick();
    kick();
    repeat (14450) tick();
    chk(wr_en == 1'b1 && pix_color == 3'd1, "R1", "in line before reset", int'(pix_color), 1);
    rst_n = 1'b0;
    #1;
    check_quiet("R1");
    tick();
    rst_n = 1'b1;
    repeat (4) tick();
    check_quiet("R1");

    report();
    $finish;
  end
endmodule